// File: doc/BRIEF.md
# Mid-Bit Sampling UART Receiver

This block receives asynchronous serial frames on an idle-high line. A frame has a start bit, a programmable number of data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit. A falling edge seen while the receiver is idle opens a frame. Each later bit is read once, near its centre, at times set by a programmable bit period counted in clock cycles. There is no oversampling and no majority vote.

While a frame is in progress the start-edge detector is disabled. Bits are collected at the top of a 24-bit shift register. Parity is tracked as a running count of received ones. At the stop bit the block stores the word, right-justified, together with an error byte. It then raises a one-cycle data-ready interrupt pulse and a one-cycle DMA request pulse in the same cycle.

Top module: `uart_midbit_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rx_data_o` and `err_word_o` are zero and `data_ready_o` and `dma_req_o` are low.
- R2: A high-to-low transition of `rx_i` while idle starts a frame. The first data bit is sampled 1.5 bit periods after the edge, and every later bit one bit period after the previous sample. `bit_period_i` is the period in clock cycles (at least 8).
- R3: Falling edges of `rx_i` inside a frame do not restart the frame. The start-edge detector is armed again only after the stop bit has been sampled.
- R4: Data bits arrive least significant bit first. `rx_data_o` holds the word right-justified: bit 0 is the first data bit, and every bit at or above the word length is 0.
- R5: The word length is taken from `word_len_i` (1 to 23) when the frame starts. With parity enabled, one extra bit is expected after the data bits.
- R6: A stop-bit sample of 0 sets bit 6 (value 0x40) of `err_word_o`.
- R7: With `par_en_i`=1 and `par_odd_i`=0 (even parity), an odd total number of ones across the data and parity bits sets bit 7 (value 0x80) of `err_word_o`.
- R8: With `par_en_i`=1 and `par_odd_i`=1 (odd parity), an even total number of ones across the data and parity bits sets bit 7 (value 0x80).
- R9: `err_word_o` is rebuilt from nothing at every stop bit, so an error in one frame never appears in the next frame.
- R10: At the end of every frame, `data_ready_o` and `dma_req_o` are high together for exactly one cycle. `rx_data_o` and `err_word_o` change only in that cycle.
- R11: With `par_en_i`=0 no parity bit is expected, and bit 7 of `err_word_o` is always 0.
- R12: Bits 0 to 5 of `err_word_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| bit_period_i | input | PER_W (16) | Bit period in clock cycles |
| word_len_i | input | WLEN_W (5) | Number of data bits, 1 to 23 |
| par_en_i | input | 1 | 1 = a parity bit follows the data |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rx_data_o | output | SHREG_W (24) | Last received word, right-justified |
| err_word_o | output | 8 | Error byte: bit 6 framing error, bit 7 parity error |
| data_ready_o | output | 1 | One-cycle pulse when a frame is complete |
| dma_req_o | output | 1 | One-cycle DMA request pulse, raised with data_ready_o |

## Verification
The bound checker watches, on every cycle, the output handshake: the two end-of-frame pulses rise together and last one cycle, and the data and error outputs hold still between pulses. It also checks that the reserved error bits stay 0. The scoreboard scenarios are needed for the rest, because those rules depend on what went onto the line. They cover sampling position at several bit periods, LSB-first reassembly and right-justification at word lengths of 1, 5, 8 and 23, and even and odd parity with good and corrupted parity bits. They also cover a low stop bit, an error frame followed by a clean frame, and data patterns full of falling edges that must not restart a frame.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  localparam int ERR_W          = 8;
  localparam int ERR_FRAME_BIT  = 6;
  localparam int ERR_PARITY_BIT = 7;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  typedef struct packed {
    logic en;
    logic odd;
  } par_cfg_t;
endpackage

// File: rtl/rx_sync_edge.sv
`timescale 1ns/1ps
module rx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  input  logic arm_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rx_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_o = chain[STAGES-1];
  assign fall_o = arm_i & prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
`timescale 1ns/1ps
module rx_bit_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  localparam int CW = PER_W + 1;

  logic [CW-1:0] cnt;
  logic          run;
  logic [CW-1:0] first_wait;
  logic [CW-1:0] next_wait;

  assign first_wait = CW'(period_i) + CW'(period_i >> 1) - CW'(1);
  assign next_wait  = CW'(period_i) - CW'(1);
  assign tick_o     = run & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start_i) begin
      run <= 1'b1;
      cnt <= first_wait;
    end else if (stop_i) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      if (cnt == '0) cnt <= next_wait;
      else           cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/rx_frame_core.sv
`timescale 1ns/1ps
module rx_frame_core
  import uart_rx_pkg::*;
#(
  parameter int SHREG_W = 24,
  parameter int WLEN_W  = $clog2(SHREG_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic               sample_i,
  input  logic [WLEN_W-1:0]  word_len_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [SHREG_W-1:0] data_o,
  output logic [ERR_W-1:0]   err_o,
  output logic               ready_o,
  output logic               dma_o
);
  localparam int CNT_W = $clog2(SHREG_W + 1);

  rx_state_e          state;
  logic [CNT_W-1:0]   bits_left;
  logic [SHREG_W-1:0] shreg;
  logic               ones_odd;
  par_cfg_t           cfg;
  logic [WLEN_W-1:0]  wlen_q;

  logic [SHREG_W-1:0] aligned;
  logic [SHREG_W-1:0] justified;
  logic [CNT_W-1:0]   shamt;
  logic [ERR_W-1:0]   err_next;
  logic               at_stop;

  assign busy_o  = (state == RX_BUSY);
  assign at_stop = busy_o & tick_i & (bits_left == '0);
  assign done_o  = at_stop;

  // Data alignment at stop time: drop the parity bit, or shift once more
  always_comb begin
    if (cfg.en) aligned = {1'b0, shreg[SHREG_W-2:0]};
    else        aligned = {1'b0, shreg[SHREG_W-1:1]};
    shamt     = CNT_W'(SHREG_W - 1) - CNT_W'(wlen_q);
    justified = aligned >> shamt;
  end

  always_comb begin
    err_next                 = '0;
    err_next[ERR_FRAME_BIT]  = ~sample_i;
    err_next[ERR_PARITY_BIT] = cfg.en & (ones_odd ^ cfg.odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      bits_left <= '0;
      shreg     <= '0;
      ones_odd  <= 1'b0;
      cfg       <= '0;
      wlen_q    <= '0;
      data_o    <= '0;
      err_o     <= '0;
      ready_o   <= 1'b0;
      dma_o     <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      dma_o   <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (start_i) begin
            state     <= RX_BUSY;
            ones_odd  <= 1'b0;
            bits_left <= CNT_W'(word_len_i) + CNT_W'(par_en_i);
            cfg       <= '{en: par_en_i, odd: par_odd_i};
            wlen_q    <= word_len_i;
          end
        end
        RX_BUSY: begin
          if (tick_i) begin
            if (bits_left == '0) begin
              state   <= RX_IDLE;
              data_o  <= justified;
              err_o   <= err_next;
              ready_o <= 1'b1;
              dma_o   <= 1'b1;
            end else begin
              shreg     <= {sample_i, shreg[SHREG_W-1:1]};
              ones_odd  <= ones_odd ^ sample_i;
              bits_left <= bits_left - CNT_W'(1);
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_midbit_rx.sv
`timescale 1ns/1ps
module uart_midbit_rx
  import uart_rx_pkg::*;
#(
  parameter int  SHREG_W     = 24,
  parameter int  PER_W       = 16,
  parameter int  SYNC_STAGES = 2,
  localparam int WLEN_W      = $clog2(SHREG_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_i,
  input  logic [PER_W-1:0]   bit_period_i,
  input  logic [WLEN_W-1:0]  word_len_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  output logic [SHREG_W-1:0] rx_data_o,
  output logic [ERR_W-1:0]   err_word_o,
  output logic               data_ready_o,
  output logic               dma_req_o
);
  logic line;
  logic fall;
  logic busy;
  logic done;
  logic tick;

  rx_sync_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk    (clk),
    .rst    (rst),
    .rx_i   (rx_i),
    .arm_i  (~busy),
    .line_o (line),
    .fall_o (fall)
  );

  rx_bit_timer #(.PER_W(PER_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (fall),
    .stop_i   (done),
    .period_i (bit_period_i),
    .tick_o   (tick)
  );

  rx_frame_core #(.SHREG_W(SHREG_W), .WLEN_W(WLEN_W)) i_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (fall),
    .tick_i     (tick),
    .sample_i   (line),
    .word_len_i (word_len_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .busy_o     (busy),
    .done_o     (done),
    .data_o     (rx_data_o),
    .err_o      (err_word_o),
    .ready_o    (data_ready_o),
    .dma_o      (dma_req_o)
  );
endmodule

// File: rtl/uart_midbit_rx_chk.sv
`timescale 1ns/1ps
module uart_midbit_rx_chk #(
  parameter int SHREG_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic [SHREG_W-1:0] rx_data_o,
  input logic [7:0]         err_word_o,
  input logic               data_ready_o,
  input logic               dma_req_o
);
  // R10
  pulse_pair_chk: assert property (@(posedge clk) disable iff (rst)
    data_ready_o == dma_req_o);

  // R10
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_ready_o |=> !data_ready_o);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_ready_o |-> ($stable(rx_data_o) && $stable(err_word_o)));

  // R12
  reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_word_o[5:0] == 6'd0);
endmodule

bind uart_midbit_rx uart_midbit_rx_chk #(.SHREG_W(SHREG_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_data_o    (rx_data_o),
  .err_word_o   (err_word_o),
  .data_ready_o (data_ready_o),
  .dma_req_o    (dma_req_o)
);

// File: tb/test_uart_midbit_rx.sv
`timescale 1ns/1ps
module test_uart_midbit_rx;
  localparam int SHREG_W = 24;
  localparam int PER_W   = 16;

  typedef struct {
    logic [23:0] data;
    logic [7:0]  err;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_i = 1'b1;
  logic [PER_W-1:0]  bit_period_i = 16'd16;
  logic [4:0]        word_len_i = 5'd8;
  logic              par_en_i = 1'b0;
  logic              par_odd_i = 1'b0;
  logic [23:0]       rx_data_o;
  logic [7:0]        err_word_o;
  logic              data_ready_o;
  logic              dma_req_o;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  uart_midbit_rx #(.SHREG_W(SHREG_W), .PER_W(PER_W)) i_uart_midbit_rx (
    .clk          (clk),
    .rst          (rst),
    .rx_i         (rx_i),
    .bit_period_i (bit_period_i),
    .word_len_i   (word_len_i),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .rx_data_o    (rx_data_o),
    .err_word_o   (err_word_o),
    .data_ready_o (data_ready_o),
    .dma_req_o    (dma_req_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic v, input int per);
    rx_i = v;
    repeat (per) @(negedge clk);
  endtask

  // Drive one frame and push its expected result
  task automatic send_frame(input logic [22:0] d, input int n, input int per,
                            input bit pe, input bit po, input bit bad_par,
                            input logic stop_v, input string tag);
    exp_t        e;
    logic [22:0] m;
    logic        pbit;
    m = d & ((23'd1 << n) - 23'd1);
    pbit = po ? ~(^m) : (^m);
    if (bad_par) pbit = ~pbit;
    e.data = {1'b0, m};
    e.err  = {(pe && bad_par), ~stop_v, 6'd0};
    e.tag  = tag;
    @(negedge clk);
    bit_period_i = PER_W'(per);
    word_len_i   = 5'(n);
    par_en_i     = pe;
    par_odd_i    = po;
    sb.push_back(e);
    line_bit(1'b0, per);
    for (int i = 0; i < n; i++) line_bit(m[i], per);
    if (pe) line_bit(pbit, per);
    line_bit(stop_v, per);
    line_bit(1'b1, 3 * per);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && data_ready_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected frame", 32'(rx_data_o), 32'hffff_ffff);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rx_data_o == e.data, {e.tag, " data R4"}, 32'(rx_data_o), 32'(e.data));
          check(err_word_o == e.err, {e.tag, " err"}, 32'(err_word_o), 32'(e.err));
          check(dma_req_o == 1'b1, "R10 dma with ready", 32'(dma_req_o), 32'd1);
          @(posedge clk);
          #1;
          check(!data_ready_o && !dma_req_o, "R10 pulse width",
                {30'd0, data_ready_o, dma_req_o}, 32'd0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 during reset
    check(rx_data_o == 24'd0 && err_word_o == 8'd0 && !data_ready_o && !dma_req_o,
          "R1 reset state", {rx_data_o, err_word_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(rx_data_o == 24'd0 && !data_ready_o, "R1 after reset", 32'(rx_data_o), 32'd0);
    repeat (10) @(negedge clk);

    send_frame(23'h0000A5, 8, 16, 1'b0, 1'b0, 1'b0, 1'b1, "R2 R5 plain 8 bit");
    send_frame(23'h000055, 8, 20, 1'b0, 1'b0, 1'b0, 1'b1, "R3 edges in frame");
    send_frame(23'h00003C, 8, 16, 1'b1, 1'b0, 1'b0, 1'b1, "R7 even good");
    send_frame(23'h000031, 8, 16, 1'b1, 1'b0, 1'b1, 1'b1, "R7 even bad");
    send_frame(23'h000001, 8, 24, 1'b1, 1'b1, 1'b0, 1'b1, "R8 odd good");
    send_frame(23'h000003, 8, 24, 1'b1, 1'b1, 1'b1, 1'b1, "R8 odd bad");
    send_frame(23'h5A5A5A, 23, 16, 1'b1, 1'b0, 1'b0, 1'b1, "R5 23 bit parity");
    send_frame(23'h7FFFFF, 23, 16, 1'b0, 1'b0, 1'b0, 1'b1, "R5 23 bit no parity");
    send_frame(23'h000013, 5, 33, 1'b0, 1'b0, 1'b1, 1'b1, "R11 parity off");
    send_frame(23'h000000, 8, 16, 1'b0, 1'b0, 1'b0, 1'b0, "R6 framing");
    send_frame(23'h0000C3, 8, 16, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clean after error");
    send_frame(23'h00002A, 7, 20, 1'b1, 1'b1, 1'b1, 1'b0, "R6 R7 both errors");
    send_frame(23'h000001, 1, 12, 1'b1, 1'b1, 1'b0, 1'b1, "R4 one bit");
    send_frame(23'h000000, 1, 12, 1'b0, 1'b0, 1'b0, 1'b1, "R4 one bit zero");

    repeat (200) @(negedge clk);
    check(sb.size() == 0, "R2 every frame received", 32'(sb.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule